// File: doc/BRIEF.md
# Memory Chip-Enable Guard with Write Completion

This block sits in series between a processor's active-low memory chip-enable and the chip-enable pin of a RAM. It keeps the RAM from being corrupted while the supply collapses. When the supervisor's reset request is low, the chip-enable passes through without any cycle of delay. When the request rises, the path closes. A write already in flight is the exception: if the chip-enable is low at that moment, the path stays open for a bounded grace window of `GRACE_CYC` clock cycles so the write can finish.

The window closes early as soon as the processor lifts its chip-enable. Once the path has closed, the RAM side is held high and any further chip-enable pulses are ignored until the supervisor releases reset. After a power-on reset of the logic itself, the guard starts closed. It reopens only when the supervisor request is low.

Top module: `ce_guard`

## Requirements
- R1: While `sup_rst` is low, `ce_out_n` equals `ce_in_n` in the same cycle and `gate_en` is 1.
- R2: In the first cycle that `sup_rst` is high, if `ce_in_n` is high (1), then `ce_out_n` is 1 and `gate_en` is 0 in that same cycle.
- R3: In the first cycle that `sup_rst` is high, if `ce_in_n` is low (0), the path stays open. `ce_out_n` is 0 and `gate_en` is 1 for as long as `ce_in_n` stays low within the grace window.
- R4: If `ce_in_n` returns to 1 during the grace window, `ce_out_n` is 1 and `gate_en` is 0 from that same cycle on, while `sup_rst` stays high.
- R5: If `ce_in_n` stays low, call cycle k the first cycle with `sup_rst` high. Then `ce_out_n` is 0 through cycle k+`GRACE_CYC`, and from cycle k+`GRACE_CYC`+1 on it is 1 with `gate_en` at 0.
- R6: Once the path has closed under `sup_rst`, driving `ce_in_n` low again leaves `ce_out_n` at 1 and `gate_en` at 0 until `sup_rst` falls.
- R7: After `rst_n` (active low) is applied, the path is closed. With `sup_rst` high, `ce_out_n` stays 1 whatever `ce_in_n` does, both during `rst_n` and after its release.
- R8: If `sup_rst` falls during the grace window, the path passes again, and a later rise of `sup_rst` with `ce_in_n` low grants a fresh full window of `GRACE_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset of the guard logic, active low |
| sup_rst | input | 1 | Reset request from the supply supervisor, active high |
| ce_in_n | input | 1 | Processor chip-enable, active low |
| ce_out_n | output | 1 | Chip-enable to the RAM, active low |
| gate_en | output | 1 | 1 while the path from `ce_in_n` to `ce_out_n` is open |

## Verification
The hardest condition to reach is the last cycle of a grace window that runs to full length. The counter must expire exactly one cycle after its final open cycle, and a write must not end early by accident. The stimulus raises `sup_rst` on a falling edge while holding `ce_in_n` low. It then keeps both inputs unchanged for exactly `GRACE_CYC` further cycles, checking every cycle, before looking for the forced high level. A second run cuts a window short by dropping `sup_rst` and asserts again at once. This shows that the counter is reloaded rather than resumed.

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int GRACE_CYC = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic gate_en
);
  localparam int CW = (GRACE_CYC < 2) ? 1 : $clog2(GRACE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(GRACE_CYC - 1);

  typedef enum logic [1:0] {PASS, GRACE, BLOCKED} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  assign gate_en  = !sup_rst || (st != BLOCKED && !ce_in_n);
  assign ce_out_n = ce_in_n || !gate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BLOCKED;
      cnt <= '0;
    end else begin
      case (st)
        PASS:
          if (sup_rst) begin
            st  <= ce_in_n ? BLOCKED : GRACE;
            cnt <= LOAD;
          end
        GRACE:
          if (!sup_rst)                    st <= PASS;
          else if (ce_in_n || cnt == '0)   st <= BLOCKED;
          else                             cnt <= cnt - 1'b1;
        default:
          if (!sup_rst) st <= PASS;
      endcase
    end
  end
endmodule

module ce_guard_chk #(
  parameter int GRACE_CYC = 4500
) (
  input logic clk,
  input logic rst_n,
  input logic sup_rst,
  input logic ce_in_n,
  input logic ce_out_n,
  input logic gate_en
);
  logic [31:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (sup_rst && !ce_out_n) low_run <= low_run + 1;
    else low_run <= '0;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_rst |-> (ce_out_n == ce_in_n && gate_en)); // R1
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sup_rst) && ce_in_n) |-> (ce_out_n && !gate_en)); // R2
  AST_STAYS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_rst && $past(sup_rst) && $past(ce_out_n)) |-> ce_out_n); // R6
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 32'(GRACE_CYC + 1)); // R5
  AST_CLOSED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> ce_out_n); // R4
endmodule

bind ce_guard ce_guard_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .ce_in_n(ce_in_n),
  .ce_out_n(ce_out_n), .gate_en(gate_en)
);

// File: tb/sim_ce_guard.sv
`timescale 1ns/1ps
module sim_ce_guard;
  localparam int G = 12;
  logic clk = 0, rst_n = 0, sup_rst = 1, ce_in_n = 1;
  logic ce_out_n, gate_en;
  int checks = 0, fails = 0;

  ce_guard #(.GRACE_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .gate_en(gate_en)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic eo, input logic ee);
    checks++;
    if (ce_out_n !== eo || gate_en !== ee) begin
      fails++;
      $display("FAIL %s: ce_out_n=%b gate_en=%b expected ce_out_n=%b gate_en=%b",
               tag, ce_out_n, gate_en, eo, ee);
    end
  endtask

  task automatic drive(input logic r, input logic c);
    @(negedge clk);
    sup_rst = r;
    ce_in_n = c;
    #1;
  endtask

  task automatic t_powerup;
    rst_n = 0;
    drive(1, 0); chk("R7 low ce in reset", 1, 0);
    drive(1, 1); chk("R7 high ce in reset", 1, 0);
    @(negedge clk); rst_n = 1;
    drive(1, 0); chk("R7 low ce after reset", 1, 0);
    drive(1, 0); chk("R7 still closed", 1, 0);
  endtask

  task automatic t_follow;
    drive(0, 0); chk("R1 follow low", 0, 1);
    drive(0, 1); chk("R1 follow high", 1, 1);
    for (int i = 0; i < 6; i++) begin
      drive(0, i[0]); chk("R1 toggle", i[0], 1);
    end
  endtask

  task automatic t_idle_entry;
    drive(0, 1);
    drive(1, 1); chk("R2 entry idle", 1, 0);
    drive(1, 0); chk("R2 later low ignored", 1, 0);
    drive(0, 0); chk("R1 release", 0, 1);
  endtask

  task automatic t_early_end;
    drive(0, 0);
    drive(1, 0); chk("R3 grace open", 0, 1);
    for (int i = 0; i < 3; i++) begin
      drive(1, 0); chk("R3 grace held", 0, 1);
    end
    drive(1, 1); chk("R4 write ends", 1, 0);
    drive(1, 0); chk("R6 relow ignored", 1, 0);
    drive(1, 0); chk("R6 relow ignored 2", 1, 0);
    drive(0, 1); chk("R1 release", 1, 1);
  endtask

  task automatic t_expire;
    drive(0, 0);
    drive(1, 0); chk("R5 cycle k", 0, 1);
    for (int i = 1; i <= G; i++) begin
      drive(1, 0); chk("R5 within window", 0, 1);
    end
    drive(1, 0); chk("R5 expired", 1, 0);
    drive(1, 1); chk("R6 high after expiry", 1, 0);
    drive(1, 0); chk("R6 low after expiry", 1, 0);
    drive(0, 0); chk("R1 release after expiry", 0, 1);
  endtask

  task automatic t_rearm;
    drive(0, 0);
    drive(1, 0); chk("R8 first window", 0, 1);
    for (int i = 0; i < G - 3; i++) drive(1, 0);
    drive(0, 0); chk("R8 released mid window", 0, 1);
    drive(1, 0); chk("R8 fresh cycle k", 0, 1);
    for (int i = 1; i <= G; i++) begin
      drive(1, 0); chk("R8 fresh window held", 0, 1);
    end
    drive(1, 0); chk("R8 fresh window expired", 1, 0);
    drive(0, 1); chk("R1 release", 1, 1);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_powerup();
    t_follow();
    t_idle_entry();
    t_early_end();
    t_expire();
    t_rearm();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule